// File: doc/BRIEF.md
# Shared Receive Queue with Overrun Markers

This block is the single receive queue shared by all serial lines of a multi-line controller. A line-service engine moves each received character into it as one 16-bit entry, built from two byte writes to two fixed addresses: the character byte first, which is only staged, then the status byte (line number plus error flags), which completes the entry. Both writes count only while the engine holds its store grant. The host removes entries by reading the receive-buffer offset of its register window. Each read returns the oldest entry with a valid flag, or an all-zero word with the flag clear when nothing is queued.

A write pointer and a read pointer, each one bit wider than the index, track the queue. When the queue is full the engine is told to stop, and any entry it completes anyway is dropped. If a line overflows while the engine is held off, the engine reports that line number. The block remembers one flag per line and, as soon as a slot is free, queues one null character per flagged line with the overrun bit set in its status byte. These markers go in lowest line number first and take precedence over new characters.

Top module: `rxq_fifo`

## Requirements
- R1: After a synchronous active-low reset, `rd_valid` is 0, `rd_data` is 0, `fifo_full` is 0 and `wr_ready` is 1.
- R2: A low-byte write (address 16'hC040) followed by a high-byte write (address 16'hC041) stores one entry; a later host read returns the high-byte data in `rd_data[15:8]` and the staged low byte in `rd_data[7:0]`.
- R3: A low-byte write by itself adds no entry; a host read after it still finds the queue empty.
- R4: A byte write without `wr_grant` asserted, or to any other address, has no effect on the queue.
- R5: A host read with `rd_off` equal to 2 updates `rd_data` and sets `rd_valid` at the next clock edge, and entries come out in the order they were stored; reads at any other offset change nothing.
- R6: A host read of an empty queue gives `rd_valid` 0 and `rd_data` 0 and removes nothing.
- R7: After 64 stored entries `fifo_full` is 1 and `wr_ready` is 0; an entry completed while full is dropped.
- R8: An overrun report for a line sets that line's flag; repeated reports for a line before its marker is queued still produce one marker.
- R9: A marker entry is 16'h00 in the low byte and, in the high byte, bit 4 (overrun) set and bits 3:0 holding the line number, all other bits 0.
- R10: While a slot is free and flags are pending, one marker is queued per clock cycle, lowest flagged line number first.
- R11: While any flag is pending, `wr_ready` is 0 and a completed character entry is dropped.
- R12: A host read and an entry store in the same cycle both take effect when the queue is not full at the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_strobe | input | 1 | Engine byte-write cycle |
| wr_grant | input | 1 | Engine holds the store grant |
| wr_addr | input | 16 | Engine write address |
| wr_data | input | 8 | Engine write byte |
| ovr_valid | input | 1 | Overrun report for one line |
| ovr_chan | input | 4 | Line number of the overrun report |
| wr_ready | output | 1 | Queue takes new characters (not full, no markers pending) |
| fifo_full | output | 1 | All 64 slots occupied |
| rd_strobe | input | 1 | Host read cycle |
| rd_off | input | 3 | Host register offset |
| rd_data | output | 16 | Entry returned by the last receive-buffer read |
| rd_valid | output | 1 | Last receive-buffer read returned an entry |

## Verification
Two functions can fall in the same cycle: a host read that frees a slot and a store into the queue, either a completed character or a marker. The bench provokes this by issuing a high-byte write and a receive-buffer read in one cycle on a partly filled queue, and by draining a full queue while line flags are pending, so each freed slot is refilled by a marker on the next edge. A behavioural queue model in the bench predicts every output each cycle, and the bench compares the two at the falling edge.

// File: rtl/rxq_pkg.sv
// Package rxq_pkg
// Shared widths and status-byte layout for the receive queue.
// Assumes at most 16 lines, so a line number fits in status bits 3:0.
package rxq_pkg;
    localparam int ENTRY_W   = 16;
    localparam int BYTE_W    = 8;
    localparam int OVR_BIT   = 4;

    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic [BYTE_W-1:0]  byte_t;

    // Build a null-character entry flagged as overrun for one line.
    function automatic entry_t marker_word(input byte_t line_field);
        byte_t st;
        st = line_field;
        st[OVR_BIT] = 1'b1;
        return {st, 8'h00};
    endfunction
endpackage

// File: rtl/rxq_ptrs.sv
// Module rxq_ptrs
// Write (fill) and read (empty) counters with an extra wrap bit.
// Assumes push is never raised while full and pop never while empty;
// the top module gates both.
module rxq_ptrs #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] rd_idx,
    output logic          full,
    output logic          empty
);
    logic [AW:0] wptr_q;
    logic [AW:0] rptr_q;

    // Fill counter: advances once per stored entry.
    always_ff @(posedge clk) begin
        if (!rst_n)    wptr_q <= '0;
        else if (push) wptr_q <= wptr_q + 1'b1;
    end

    // Empty counter: advances once per entry handed to the host.
    always_ff @(posedge clk) begin
        if (!rst_n)   rptr_q <= '0;
        else if (pop) rptr_q <= rptr_q + 1'b1;
    end

    // Occupancy flags from the pointer pair.
    always_comb begin
        wr_idx = wptr_q[AW-1:0];
        rd_idx = rptr_q[AW-1:0];
        empty  = (wptr_q == rptr_q);
        full   = (wptr_q[AW] != rptr_q[AW]) && (wr_idx == rd_idx);
    end

    p_push_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    p_pop_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/rxq_ovr_track.sv
// Module rxq_ovr_track
// One pending-overrun flag per line and a lowest-first selector.
// Assumes 'take' is high only when the queue has a free slot; a report
// in the same cycle as that line's marker leaves the flag set.
module rxq_ovr_track #(
    parameter int NCH  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rep_valid,
    input  logic [CHW-1:0] rep_chan,
    input  logic           take,
    output logic           any_pend,
    output logic           ins_valid,
    output logic [CHW-1:0] ins_chan
);
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] ins_mask;
    logic [NCH-1:0] rep_mask;

    // Lowest-numbered pending line wins.
    always_comb begin
        ins_chan = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_q[i]) ins_chan = CHW'(i);
        end
        any_pend  = |pend_q;
        ins_valid = take && any_pend;
    end

    // Decode the inserted line and the reported line to masks.
    always_comb begin
        ins_mask = '0;
        rep_mask = '0;
        if (ins_valid) ins_mask[ins_chan] = 1'b1;
        if (rep_valid) rep_mask[rep_chan] = 1'b1;
    end

    // Per-line flag: a report sets it, its own marker clears it.
    for (genvar g = 0; g < NCH; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)           pend_q[g] <= 1'b0;
            else if (rep_mask[g]) pend_q[g] <= 1'b1;
            else if (ins_mask[g]) pend_q[g] <= 1'b0;
        end
    end

    p_one_marker_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ins_mask));
    p_lowest_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> ((pend_q & (ins_mask - 1'b1)) == '0));
    p_report_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |=> any_pend);
endmodule

// File: rtl/rxq_store.sv
// Module rxq_store
// Entry storage, low-byte staging register and the host read register.
// Assumes at most one of commit_char / commit_mark per cycle and that
// rd_ok is low whenever the queue is empty.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stage_we,
    input  byte_t         byte_d,
    input  logic          commit_char,
    input  logic          commit_mark,
    input  entry_t        mark_word,
    input  logic [AW-1:0] wr_idx,
    input  logic          rd_en,
    input  logic          rd_ok,
    input  logic [AW-1:0] rd_idx,
    output entry_t        rd_data,
    output logic          rd_valid
);
    entry_t mem [DEPTH];
    byte_t  stage_q;
    entry_t word_in;

    // Character byte waits here until its status byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (stage_we) stage_q <= byte_d;
    end

    // Select what is written this cycle.
    always_comb begin
        word_in = commit_mark ? mark_word : {byte_d, stage_q};
    end

    // Slot array, written at the fill index.
    always_ff @(posedge clk) begin
        if (commit_char || commit_mark) mem[wr_idx] <= word_in;
    end

    // Host read register: oldest entry, or zero with valid clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else if (rd_en) begin
            rd_data  <= rd_ok ? mem[rd_idx] : '0;
            rd_valid <= rd_ok;
        end
    end

    p_single_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_char && commit_mark));
    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_ok) |=> (!rd_valid && rd_data == '0));
    p_read_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_ok) |=> rd_valid);
endmodule

// File: rtl/rxq_fifo.sv
// Module rxq_fifo (top)
// Shared receive queue: address-decoded byte writes build entries,
// host reads of the receive-buffer offset remove them, and pending
// line overruns are queued as null markers ahead of new characters.
// Assumes the engine presents the low byte before the high byte.
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int          DEPTH    = 64,
    parameter int          NCH      = 16,
    parameter int          ADDR_W   = 16,
    parameter int          OFF_W    = 3,
    parameter logic [15:0] LO_ADDR  = 16'hC040,
    parameter logic [15:0] HI_ADDR  = 16'hC041,
    parameter int          RBUF_OFF = 2,
    localparam int AW  = $clog2(DEPTH),
    localparam int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic              wr_grant,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              ovr_valid,
    input  logic [CHW-1:0]    ovr_chan,
    output logic              wr_ready,
    output logic              fifo_full,
    input  logic              rd_strobe,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [15:0]       rd_data,
    output logic              rd_valid
);
    logic          lo_hit, hi_hit, rd_hit;
    logic          full, empty;
    logic          any_pend, ins_valid;
    logic [CHW-1:0] ins_chan;
    logic          commit_char, push, pop;
    logic [AW-1:0] wr_idx, rd_idx;
    entry_t        mark_word;

    // Address decode qualified by the engine's grant and host offset.
    always_comb begin
        lo_hit = wr_strobe && wr_grant && (wr_addr == ADDR_W'(LO_ADDR));
        hi_hit = wr_strobe && wr_grant && (wr_addr == ADDR_W'(HI_ADDR));
        rd_hit = rd_strobe && (rd_off == OFF_W'(RBUF_OFF));
    end

    // Admission: markers first, characters only with no flag pending.
    always_comb begin
        commit_char = hi_hit && !full && !any_pend;
        push        = commit_char || ins_valid;
        pop         = rd_hit && !empty;
        mark_word   = marker_word({{(8-CHW){1'b0}}, ins_chan});
        wr_ready    = !full && !any_pend;
        fifo_full   = full;
    end

    rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .pop    (pop),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx),
        .full   (full),
        .empty  (empty)
    );

    rxq_ovr_track #(.NCH(NCH)) u_ovr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rep_valid (ovr_valid),
        .rep_chan  (ovr_chan),
        .take      (!full),
        .any_pend  (any_pend),
        .ins_valid (ins_valid),
        .ins_chan  (ins_chan)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .stage_we    (lo_hit),
        .byte_d      (wr_data),
        .commit_char (commit_char),
        .commit_mark (ins_valid),
        .mark_word   (mark_word),
        .wr_idx      (wr_idx),
        .rd_en       (rd_hit),
        .rd_ok       (!empty),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

    p_pending_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_hit && any_pend) |-> !commit_char);
    p_ungranted_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_grant && !ins_valid) |-> !push);
    p_lo_no_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_hit && !ins_valid) |-> !push);
    p_full_no_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !wr_ready);
endmodule

// File: tb/tb_rxq_fifo.sv
// Bench for rxq_fifo: behavioural queue model, compared every cycle.
module tb_rxq_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_strobe = 1'b0, wr_grant = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ovr_valid = 1'b0;
    logic [3:0]  ovr_chan = '0;
    logic        rd_strobe = 1'b0;
    logic [2:0]  rd_off = '0;
    logic        wr_ready, fifo_full, rd_valid;
    logic [15:0] rd_data;

    int    n_vec = 0, n_bad = 0, cycles = 0;
    string phase = "R1";
    bit    live = 1'b0;

    // Reference model state.
    logic [15:0] mq[$];
    bit   [15:0] mpend;
    logic [7:0]  mstage;
    logic [15:0] e_data;
    bit          e_valid;

    rxq_fifo dut (.*);

    always #5 clk = ~clk;

    // Model update on each rising edge from the inputs held across it.
    always @(posedge clk) begin
        bit was_full;
        bit hi, lo;
        if (!rst_n) begin
            mq.delete(); mpend = '0; mstage = '0; e_data = '0; e_valid = 0;
            live = 1'b1;
        end else begin
            was_full = (mq.size() == 64);
            lo = wr_strobe && wr_grant && wr_addr == 16'hC040;
            hi = wr_strobe && wr_grant && wr_addr == 16'hC041;
            if (rd_strobe && rd_off == 3'd2) begin
                if (mq.size() > 0) begin e_data = mq.pop_front(); e_valid = 1; end
                else begin e_data = '0; e_valid = 0; end
            end
            if (!was_full && mpend != 0) begin
                for (int i = 0; i < 16; i++) begin
                    if (mpend[i]) begin
                        mq.push_back({8'h10 | 8'(i), 8'h00});
                        mpend[i] = 1'b0;
                        break;
                    end
                end
            end else if (hi && !was_full) begin
                mq.push_back({wr_data, mstage});
            end
            if (lo) mstage = wr_data;
            if (ovr_valid) mpend[ovr_chan] = 1'b1;
        end
    end

    // Compare at the falling edge.
    always @(negedge clk) begin
        bit ef, er;
        if (live) begin
            ef = (mq.size() == 64);
            er = !ef && (mpend == 0);
            n_vec++;
            if (rd_data !== e_data || rd_valid !== e_valid ||
                fifo_full !== ef || wr_ready !== er) begin
                n_bad++;
                $display("FAIL %s: data=%h valid=%b full=%b ready=%b exp data=%h valid=%b full=%b ready=%b",
                         phase, rd_data, rd_valid, fifo_full, wr_ready,
                         e_data, e_valid, ef, er);
            end
        end
    end

    task automatic drive(input bit s, input bit g, input logic [15:0] a,
                         input logic [7:0] d, input bit r, input logic [2:0] o,
                         input bit ov, input logic [3:0] ch);
        wr_strobe = s; wr_grant = g; wr_addr = a; wr_data = d;
        rd_strobe = r; rd_off = o; ovr_valid = ov; ovr_chan = ch;
        @(posedge clk); #2;
        wr_strobe = 0; wr_grant = 0; rd_strobe = 0; ovr_valid = 0;
    endtask
    task automatic idle();                  drive(0,0,16'h0,8'h0,0,3'd0,0,4'd0); endtask
    task automatic wlo(input logic [7:0] d); drive(1,1,16'hC040,d,0,3'd0,0,4'd0); endtask
    task automatic whi(input logic [7:0] d); drive(1,1,16'hC041,d,0,3'd0,0,4'd0); endtask
    task automatic rd();                     drive(0,0,16'h0,8'h0,1,3'd2,0,4'd0); endtask
    task automatic ovr(input logic [3:0] c); drive(0,0,16'h0,8'h0,0,3'd0,1,c); endtask
    task automatic wpair(input logic [7:0] l, input logic [7:0] h);
        wlo(l); whi(h);
    endtask

    // Explicit value check at the sampling point.
    task automatic expect_word(input string tag, input logic [15:0] exp);
        #3;
        n_vec++;
        if (rd_data !== exp || rd_valid !== 1'b1) begin
            n_bad++;
            $display("FAIL %s: word=%h valid=%b exp %h valid=1", tag, rd_data, rd_valid, exp);
        end
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        phase = "R1"; idle(); idle();

        phase = "R2"; wpair(8'h41, 8'h03); wpair(8'h42, 8'h07);
        rd(); expect_word("R2", 16'h0341);
        phase = "R5"; rd(); expect_word("R5", 16'h0742);
        drive(0,0,16'h0,8'h0,1,3'd3,0,4'd0);

        phase = "R3"; wlo(8'h55); rd(); idle();
        phase = "R4"; wlo(8'h66); drive(1,0,16'hC041,8'h01,0,3'd0,0,4'd0);
        drive(1,1,16'hC042,8'h02,0,3'd0,0,4'd0); rd();
        phase = "R6"; rd(); rd(); idle();

        phase = "R12"; wpair(8'h70, 8'h01); wlo(8'h71);
        drive(1,1,16'hC041,8'h02,1,3'd2,0,4'd0); idle();
        rd(); expect_word("R12", 16'h0271);

        phase = "R7";
        for (int i = 0; i < 64; i++) wpair(8'(i), 8'h0A);
        idle(); whi(8'hEE); idle();

        phase = "R8"; ovr(4'd5); ovr(4'd2); ovr(4'd5); ovr(4'd11);
        phase = "R10";
        while (mq.size() > 0 || mpend != 0) rd();
        rd();

        phase = "R11"; wpair(8'h30, 8'h04); ovr(4'd3); whi(8'h05); idle();
        phase = "R9"; rd(); expect_word("R9", 16'h0430);
        rd(); expect_word("R9", 16'h1300);
        rd(); idle();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d exp below 20000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule